// File: doc/BRIEF.md
# Serial Character Frame Builder and Checker

This block turns one data word into the complete serial character frame a transmitter would put on the line, and then checks that frame as a receiver with its own line settings would. The frame comes out as a parallel bit vector, first bit on the line at bit 0, together with the number of valid bits in it. The checking side returns the word it recovered and two flags: one for a wrong parity bit and one for a missing stop bit. The transmit and receive settings are separate inputs. When they disagree, for example in word length, parity mode or stop-bit count, the check reports the errors a real receiver would see.

A transmit bit limit can cut the data part of the frame short, which models a character that is broken off mid-word. The block has one register stage. A result is presented one clock after its input strobe and is held until the next strobe. A small two-state controller, with states `ST_IDLE` and `ST_SHOW`, sequences the handshake. A strobe in either state moves it to `ST_SHOW`, and a cycle without a strobe returns it to `ST_IDLE`. Bit-serial timing and character buffering are left to the blocks around it.

Top module: `uart_frame_codec`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `frame_bits`, `frame_len`, `rx_data`, `rx_par_err` and `rx_frm_err` are all 0 until the first strobe has been captured.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. All result outputs change only on a strobe and hold their values otherwise.
- R3: Each 6-bit line-control input is laid out as follows: bits [1:0] hold the length code, bit 2 selects two stop bits, bit 3 enables parity, bit 4 selects even parity and bit 5 selects stick parity.
- R4: The transmit word length is the length code plus 5. The data bits are the low bits of `in_data`, placed starting with bit 0 at `frame_bits[0]`.
- R5: When transmit parity is enabled, the bit after the data bits is 1 under stick parity. Otherwise it is the XOR of the sent data bits for even parity, and its inverse for odd parity.
- R6: After the data bits and the parity bit, if present, comes one stop bit of value 1. A second stop bit of value 1 follows when two stop bits are selected. `frame_len` is the total bit count, and the bits of `frame_bits` above it are 0.
- R7: The number of data bits sent is the smaller of `tx_bit_limit` and the transmit word length. Parity is computed over the bits that were actually sent.
- R8: `rx_data` holds the low `(receive length code + 5)` bits of the frame, and its upper bits are 0.
- R9: When receive parity is enabled, the parity XOR is taken over the receive data bits and the bit after them. Under stick parity, `rx_par_err` is 1 when that following bit is 0. Under even parity it is 1 when the XOR is 1. Under odd parity it is 1 when the XOR is 0.
- R10: When receive parity is disabled, `rx_par_err` is 0 and the first stop bit is expected directly after the receive data bits.
- R11: `rx_frm_err` is 1 when the first expected stop bit is 0, or when two stop bits are selected on the receive side and the second is 0.
- R12: When both control inputs are equal and `tx_bit_limit` is not below the word length, both error flags are 0 and `rx_data` equals the masked input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture a new result |
| in_data | input | 8 | Data word to frame |
| tx_ctl | input | 6 | Transmit line-control settings (R3 layout) |
| rx_ctl | input | 6 | Receive line-control settings (R3 layout) |
| tx_bit_limit | input | 4 | Upper bound on the number of data bits sent |
| out_valid | output | 1 | Result presented this cycle |
| frame_bits | output | 11 | Frame, first line bit at bit 0 |
| frame_len | output | 4 | Number of valid frame bits |
| rx_data | output | 8 | Word recovered by the receive check |
| rx_par_err | output | 1 | Parity error seen by the receive check |
| rx_frm_err | output | 1 | Stop bit missing at the receive check |

## Verification
The properties assume that every input is at a known 0 or 1 on each rising edge while reset is released. The error-free property for matched settings also assumes that both control inputs are compared in the same cycle as the strobe. The stimulus changes inputs only on falling edges and never leaves a bit undriven. It mixes random control pairs, half of them forced equal so that the matched-settings path is exercised often, with directed mismatches in length, parity mode and stop count. The bit limit is drawn over its full range, including 0 and values above 8.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

    // Shortest word length; the length code adds 0..3 to it.
    localparam int WORD_MIN = 5;
    localparam int LEN_FW   = 2;
    localparam int DATA_W   = WORD_MIN + (1 << LEN_FW) - 1;
    // Data bits plus one parity and two stop bits.
    localparam int FRAME_W  = DATA_W + 3;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int CTL_W    = LEN_FW + 4;

    typedef struct packed {
        logic              stick;
        logic              even;
        logic              par_en;
        logic              two_stop;
        logic [LEN_FW-1:0] len;
    } lctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } hs_state_t;

endpackage

// File: rtl/uart_frame_encoder.sv
module uart_frame_encoder
    import uart_frame_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    input  lctl_t              ctl_i,
    input  logic [CNT_W-1:0]   limit_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o
);

    logic [CNT_W-1:0]   wlen;
    logic [CNT_W-1:0]   nsend;
    logic [CNT_W-1:0]   pos_s1;
    logic [CNT_W-1:0]   pos_s2;
    logic [FRAME_W-1:0] dext;
    logic               par_x;
    logic               par_bit;

    assign wlen    = CNT_W'(ctl_i.len) + CNT_W'(WORD_MIN);
    assign nsend   = (limit_i < wlen) ? limit_i : wlen;
    assign dext    = FRAME_W'(data_i);
    assign pos_s1  = nsend + CNT_W'(ctl_i.par_en);
    assign pos_s2  = pos_s1 + CNT_W'(1);
    assign len_o   = pos_s2 + CNT_W'(ctl_i.two_stop);

    always_comb begin
        par_x = 1'b0;
        for (int j = 0; j < DATA_W; j++) begin
            if (CNT_W'(j) < nsend) begin
                par_x = par_x ^ data_i[j];
            end
        end
    end

    assign par_bit = ctl_i.stick ? 1'b1 : (ctl_i.even ? par_x : ~par_x);

    // Each frame position picks its source by comparing with the
    // computed boundaries, so no variable shifter is needed.
    for (genvar g = 0; g < FRAME_W; g++) begin : g_pos
        logic in_data, at_par, at_s1, at_s2;
        assign in_data = CNT_W'(g) < nsend;
        assign at_par  = ctl_i.par_en && (CNT_W'(g) == nsend);
        assign at_s1   = CNT_W'(g) == pos_s1;
        assign at_s2   = ctl_i.two_stop && (CNT_W'(g) == pos_s2);
        assign frame_o[g] = in_data ? dext[g] :
                            at_par  ? par_bit :
                            (at_s1 || at_s2);
    end

endmodule

// File: rtl/uart_frame_checker.sv
module uart_frame_checker
    import uart_frame_pkg::*;
(
    input  logic [FRAME_W-1:0] frame_i,
    input  lctl_t              ctl_i,
    output logic [DATA_W-1:0]  data_o,
    output logic               par_err_o,
    output logic               frm_err_o
);

    logic [CNT_W-1:0] rlen;
    logic [CNT_W-1:0] pos_s1;
    logic [CNT_W-1:0] pos_s2;
    logic             sum_x;
    logic             bit_par;
    logic             bit_s1;
    logic             bit_s2;

    assign rlen   = CNT_W'(ctl_i.len) + CNT_W'(WORD_MIN);
    assign pos_s1 = rlen + CNT_W'(ctl_i.par_en);
    assign pos_s2 = pos_s1 + CNT_W'(1);

    for (genvar g = 0; g < DATA_W; g++) begin : g_data
        assign data_o[g] = (CNT_W'(g) < rlen) & frame_i[g];
    end

    always_comb begin
        sum_x   = 1'b0;
        bit_par = 1'b0;
        bit_s1  = 1'b0;
        bit_s2  = 1'b0;
        for (int j = 0; j < FRAME_W; j++) begin
            if (CNT_W'(j) <= rlen) begin
                sum_x = sum_x ^ frame_i[j];
            end
            if (CNT_W'(j) == rlen) begin
                bit_par = frame_i[j];
            end
            if (CNT_W'(j) == pos_s1) begin
                bit_s1 = frame_i[j];
            end
            if (CNT_W'(j) == pos_s2) begin
                bit_s2 = frame_i[j];
            end
        end
    end

    always_comb begin
        if (!ctl_i.par_en) begin
            par_err_o = 1'b0;
        end else if (ctl_i.stick) begin
            par_err_o = ~bit_par;
        end else if (ctl_i.even) begin
            par_err_o = sum_x;
        end else begin
            par_err_o = ~sum_x;
        end
    end

    assign frm_err_o = ~bit_s1 | (ctl_i.two_stop & ~bit_s2);

endmodule

// File: rtl/uart_frame_ctrl.sv
module uart_frame_ctrl
    import uart_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic valid_o
);

    hs_state_t state_q;
    hs_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load_o  = start_i;
        valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SHOW;
                end
            end
            ST_SHOW: begin
                valid_o = 1'b1;
                if (!start_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/uart_frame_codec.sv
module uart_frame_codec
    import uart_frame_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [CTL_W-1:0]   tx_ctl,
    input  logic [CTL_W-1:0]   rx_ctl,
    input  logic [CNT_W-1:0]   tx_bit_limit,
    output logic               out_valid,
    output logic [FRAME_W-1:0] frame_bits,
    output logic [CNT_W-1:0]   frame_len,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_par_err,
    output logic               rx_frm_err
);

    lctl_t              tx_s;
    lctl_t              rx_s;
    logic [FRAME_W-1:0] enc_frame;
    logic [CNT_W-1:0]   enc_len;
    logic [DATA_W-1:0]  chk_data;
    logic               chk_pe;
    logic               chk_fe;
    logic               load;

    assign tx_s = lctl_t'(tx_ctl);
    assign rx_s = lctl_t'(rx_ctl);

    uart_frame_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (in_valid),
        .load_o  (load),
        .valid_o (out_valid)
    );

    uart_frame_encoder u_enc (
        .data_i  (in_data),
        .ctl_i   (tx_s),
        .limit_i (tx_bit_limit),
        .frame_o (enc_frame),
        .len_o   (enc_len)
    );

    uart_frame_checker u_chk (
        .frame_i   (enc_frame),
        .ctl_i     (rx_s),
        .data_o    (chk_data),
        .par_err_o (chk_pe),
        .frm_err_o (chk_fe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_bits <= '0;
            frame_len  <= '0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else if (load) begin
            frame_bits <= enc_frame;
            frame_len  <= enc_len;
            rx_data    <= chk_data;
            rx_par_err <= chk_pe;
            rx_frm_err <= chk_fe;
        end
    end

endmodule

// File: rtl/uart_frame_codec_sva.sv
module uart_frame_codec_sva
    import uart_frame_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [CTL_W-1:0]   tx_ctl,
    input logic [CTL_W-1:0]   rx_ctl,
    input logic [CNT_W-1:0]   tx_bit_limit,
    input logic               out_valid,
    input logic [FRAME_W-1:0] frame_bits,
    input logic [CNT_W-1:0]   frame_len,
    input logic [DATA_W-1:0]  rx_data,
    input logic               rx_par_err,
    input logic               rx_frm_err
);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(frame_bits) && $stable(rx_data)
                       && $stable(rx_par_err) && $stable(rx_frm_err)));

    // R6
    last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((frame_bits >> (frame_len - CNT_W'(1))) == FRAME_W'(1)));

    // R6
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (frame_len <= CNT_W'(FRAME_W) && frame_len != '0));

    // R10
    no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rx_ctl[3]) |=> !rx_par_err);

    // R12
    matched_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tx_ctl == rx_ctl
         && tx_bit_limit >= (CNT_W'(tx_ctl[1:0]) + CNT_W'(WORD_MIN)))
        |=> (!rx_par_err && !rx_frm_err));

endmodule

bind uart_frame_codec uart_frame_codec_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .tx_ctl       (tx_ctl),
    .rx_ctl       (rx_ctl),
    .tx_bit_limit (tx_bit_limit),
    .out_valid    (out_valid),
    .frame_bits   (frame_bits),
    .frame_len    (frame_len),
    .rx_data      (rx_data),
    .rx_par_err   (rx_par_err),
    .rx_frm_err   (rx_frm_err)
);

// File: tb/uart_frame_codec_tb.sv
`timescale 1ns/1ps
module uart_frame_codec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic [5:0]  tx_ctl = '0;
    logic [5:0]  rx_ctl = '0;
    logic [3:0]  tx_bit_limit = '0;
    logic        out_valid;
    logic [10:0] frame_bits;
    logic [3:0]  frame_len;
    logic [7:0]  rx_data;
    logic        rx_par_err;
    logic        rx_frm_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_frame_codec u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .tx_ctl       (tx_ctl),
        .rx_ctl       (rx_ctl),
        .tx_bit_limit (tx_bit_limit),
        .out_valid    (out_valid),
        .frame_bits   (frame_bits),
        .frame_len    (frame_len),
        .rx_data      (rx_data),
        .rx_par_err   (rx_par_err),
        .rx_frm_err   (rx_frm_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench model: ctl bits [1:0] len code, [2] two stop, [3] parity on,
    // [4] even, [5] stick.
    task automatic model(input logic [7:0] d, input logic [5:0] tc, input logic [5:0] rc,
                         input logic [3:0] lim, output logic [10:0] fr, output logic [3:0] fl,
                         output logic [7:0] rd, output logic pe, output logic fe);
        int n, wl, ns, rl, k;
        logic p, x;
        fr = '0; n = 0; p = 1'b0;
        wl = int'(tc[1:0]) + 5;
        ns = (int'(lim) < wl) ? int'(lim) : wl;
        for (int i = 0; i < ns; i++) begin
            fr[n] = d[i]; p ^= d[i]; n++;
        end
        if (tc[3]) begin
            fr[n] = tc[5] ? 1'b1 : (tc[4] ? p : ~p); n++;
        end
        fr[n] = 1'b1; n++;
        if (tc[2]) begin
            fr[n] = 1'b1; n++;
        end
        fl = 4'(n);
        rl = int'(rc[1:0]) + 5;
        rd = '0;
        for (int i = 0; i < rl; i++) rd[i] = fr[i];
        x = 1'b0;
        for (int i = 0; i <= rl; i++) x ^= fr[i];
        k = rl;
        if (rc[3]) begin
            pe = rc[5] ? ~fr[rl] : (rc[4] ? (x != 1'b0) : (x != 1'b1));
            k++;
        end else begin
            pe = 1'b0;
        end
        fe = ~fr[k];
        if (rc[2]) fe |= ~fr[k+1];
    endtask

    task automatic apply(input logic [7:0] d, input logic [5:0] tc, input logic [5:0] rc,
                         input logic [3:0] lim, input string tag);
        logic [10:0] efr; logic [3:0] efl; logic [7:0] erd; logic epe, efe;
        model(d, tc, rc, lim, efr, efl, erd, epe, efe);
        @(negedge clk);
        in_data = d; tx_ctl = tc; rx_ctl = rc; tx_bit_limit = lim; in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " R2 valid"}, 32'(out_valid), 32'd1);
        chk({tag, " R3 R4 R5 R7 frame"}, 32'(frame_bits), 32'(efr));
        chk({tag, " R6 length"}, 32'(frame_len), 32'(efl));
        chk({tag, " R8 data"}, 32'(rx_data), 32'(erd));
        chk({tag, " R9 R10 parity err"}, 32'(rx_par_err), 32'(epe));
        chk({tag, " R11 framing err"}, 32'(rx_frm_err), 32'(efe));
        in_valid = 1'b0;
    endtask

    initial begin
        logic [10:0] hold_fr;
        logic [7:0]  hold_rd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(out_valid), 32'd0);
        chk("R1 reset frame", 32'(frame_bits), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({out_valid, frame_len, rx_data, rx_par_err, rx_frm_err}), 32'd0);

        // R12: matched 8 bits, no parity, one stop
        apply(8'hA5, 6'b000011, 6'b000011, 4'd8, "R12 8N1");
        chk("R12 clean data", 32'(rx_data), 32'hA5);
        // R12: matched 5 bits odd parity, two stops, upper data bits masked
        apply(8'hFF, 6'b001100, 6'b001100, 4'd15, "R12 5O2");
        chk("R12 clean flags", 32'({rx_par_err, rx_frm_err}), 32'd0);
        // R5: stick parity sent, even parity expected
        apply(8'h00, 6'b101011, 6'b011011, 4'd8, "R5 R9 stick vs even");
        chk("R9 stick mismatch flag", 32'(rx_par_err), 32'd1);
        // R7: limit 0 leaves only parity and stop bits
        apply(8'hFF, 6'b011111, 6'b011111, 4'd0, "R7 zero limit");
        // R11: receiver expects longer word than sent
        apply(8'h3C, 6'b000000, 6'b000111, 4'd8, "R11 length mismatch");
        // R10: sender adds parity, receiver has none
        apply(8'h81, 6'b011011, 6'b000011, 4'd8, "R10 rx no parity");

        // R2: inputs change without a strobe, outputs must hold
        hold_fr = frame_bits; hold_rd = rx_data;
        in_data = 8'h5A; tx_ctl = 6'b101101; rx_ctl = 6'b000000; tx_bit_limit = 4'd3;
        @(negedge clk);
        @(negedge clk);
        chk("R2 no strobe valid", 32'(out_valid), 32'd0);
        chk("R2 frame hold", 32'(frame_bits), 32'(hold_fr));
        chk("R2 data hold", 32'(rx_data), 32'(hold_rd));

        for (int t = 0; t < 400; t++) begin
            logic [5:0] tc, rc;
            tc = 6'($urandom);
            rc = ($urandom % 2 == 0) ? tc : 6'($urandom);
            apply(8'($urandom), tc, rc, 4'($urandom), "random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule